// File: doc/BRIEF.md
# External-Clock Capture Front End

This block is the sampling stage of a 16-channel logic analyzer running from a 50 MHz base clock. Every input passes through a synchronizer into the base domain. In internal mode the block takes a snapshot of all channels once every N base cycles, where N comes from a programmable divider. In external mode one channel is used as the sample clock. Each qualifying edge on that channel (rising, falling or either) captures all channels. Every snapshot carries a timestamp counted in base-clock ticks, so a capture driven by an irregular external clock can still be placed on an exact 20 ns timeline.

Configuration arrives as a stream of four bytes, one per strobe, in this order: mode byte, divider byte, mask high byte, mask low byte. The new settings take effect together when the fourth byte is accepted. The output is a stream of valid/data/timestamp words. A separate marker pulse is raised when the 16-bit timestamp rolls over after a whole window with no sample, so a consumer can count rollovers and rebuild absolute time.

Top module: `xcap_front`

## Requirements
- R1: While reset is held and on the first clock after its release, `smp_valid` and `smp_mark` are 0. Reset selects internal mode, divider 0 and no disabled pins, and clears the synchronizers and the timestamp.
- R2: In internal mode (mode bit 0 = 0) a sample is emitted once every divider+1 base cycles. The divider count restarts from zero on the cycle the configuration is committed, so the first sample under a new setting comes divider+1 cycles after the commit.
- R3: Configuration bytes are accepted on `cfg_valid` in the fixed order mode, divider, mask[15:8], mask[7:0]. None of them affects behaviour until the fourth is accepted, and then all of them apply at once.
- R4: Mode bit 0 = 1 selects external mode. In that mode samples are taken only on qualifying edges of the selected channel, and the divider count has no effect.
- R5: In external mode, divider bits 3:0 hold the channel number plus one. The value 0 wraps around and selects channel 15.
- R6: Divider bit 4 enables rising edges and bit 5 enables falling edges of the clock channel; setting both samples on either edge. With neither bit set, external mode produces no samples.
- R7: `smp_data` is the synchronized input word with every bit set in the disable mask forced to 0. A change on a pin first shows in a sample emitted on the third rising clock edge after it.
- R8: `smp_ts` equals the number of base clock cycles since reset (modulo 2^16), taken one cycle before the sample appears.
- R9: When the timestamp passes 0xFFFF to 0 and no sample has been taken since the previous rollover (including the rollover cycle itself), `smp_mark` pulses for one cycle.
- R10: `smp_mark` is never high together with `smp_valid`, and while it is high `smp_ts` reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Strobe for one configuration byte |
| cfg_byte | input | 8 | Configuration byte (mode, divider, mask high, mask low) |
| pins | input | 16 | Asynchronous logic analyzer inputs |
| smp_valid | output | 1 | A sample is present this cycle |
| smp_data | output | 16 | Captured channel word, disabled channels zeroed |
| smp_ts | output | 16 | Timestamp in base-clock ticks |
| smp_mark | output | 1 | Rollover marker for an idle timestamp window |

## Verification
Internal mode is run with dividers of 0, 2, 4 and 9 on random input words. This separates an off-by-one in the divider count from a phase that fails to restart on commit. External mode is run with random toggling on the selected channel under rising-only, falling-only, both-edges and no-edge settings. The edge patterns tell the polarity qualifiers apart, and the random words on the other channels show whether data is captured at the correct pipeline depth. Selecting channel 3 and then using the wrapping field value 0 checks that the pin index decodes correctly. A half-sent configuration held for many cycles checks that nothing takes effect early. Finally, a run idle across two full timestamp windows checks that the marker appears only after the window that had no samples.

// File: rtl/xcap_pkg.sv
package xcap_pkg;
   localparam int PINF_W       = 4;
   localparam int MODE_EXT_BIT = 0;
   localparam int DIV_RISE_BIT = 4;
   localparam int DIV_FALL_BIT = 5;

   typedef struct packed {
      logic              ext;
      logic [PINF_W-1:0] pin_f;
      logic              rise;
      logic              fall;
      logic [7:0]        div;
      logic [15:0]       mask;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{ext: 1'b0, pin_f: '0, rise: 1'b0,
                                  fall: 1'b0, div: 8'd0, mask: 16'd0};

   typedef enum logic [1:0] {SLOT_MODE, SLOT_DIV, SLOT_MHI, SLOT_MLO} slot_e;
endpackage

// File: rtl/xcap_cfg_loader.sv
module xcap_cfg_loader
   import xcap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_valid,
   input  logic [7:0] cfg_byte,
   output cfg_t       act,
   output logic       commit
);
   slot_e      slot;
   logic       sh_ext;
   logic [7:0] sh_div;
   logic [7:0] sh_mhi;

   assign commit = cfg_valid && (slot == SLOT_MLO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot   <= SLOT_MODE;
         sh_ext <= 1'b0;
         sh_div <= 8'd0;
         sh_mhi <= 8'd0;
         act    <= CFG_RESET;
      end else if (cfg_valid) begin
         unique case (slot)
            SLOT_MODE: begin
               sh_ext <= cfg_byte[MODE_EXT_BIT];
               slot   <= SLOT_DIV;
            end
            SLOT_DIV: begin
               sh_div <= cfg_byte;
               slot   <= SLOT_MHI;
            end
            SLOT_MHI: begin
               sh_mhi <= cfg_byte;
               slot   <= SLOT_MLO;
            end
            SLOT_MLO: begin
               act <= '{ext:   sh_ext,
                        pin_f: sh_div[PINF_W-1:0],
                        rise:  sh_div[DIV_RISE_BIT],
                        fall:  sh_div[DIV_FALL_BIT],
                        div:   sh_div,
                        mask:  {sh_mhi, cfg_byte}};
               slot <= SLOT_MODE;
            end
         endcase
      end
   end
endmodule

// File: rtl/xcap_pin_sync.sv
module xcap_pin_sync #(
   parameter int NCH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] pins,
   output logic [NCH-1:0] s_new,
   output logic [NCH-1:0] s_old
);
   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [2:0] stg;
      always_ff @(posedge clk) begin
         if (!rst_n) stg <= 3'b000;
         else        stg <= {stg[1:0], pins[g]};
      end
      assign s_new[g] = stg[1];
      assign s_old[g] = stg[2];
   end
endmodule

// File: rtl/xcap_sample_ctl.sv
module xcap_sample_ctl
   import xcap_pkg::*;
#(
   parameter int NCH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext,
   input  logic [PINF_W-1:0] pin_f,
   input  logic              rise,
   input  logic              fall,
   input  logic [7:0]        div,
   input  logic              commit,
   input  logic [NCH-1:0]    s_new,
   input  logic [NCH-1:0]    s_old,
   output logic              take
);
   localparam int PSEL_W = $clog2(NCH);

   logic [PINF_W-1:0] pin_m1;
   logic [PSEL_W-1:0] sel;
   logic [7:0]        dcnt;
   logic              hit, rise_ev, fall_ev;

   assign pin_m1  = pin_f - PINF_W'(1);
   assign sel     = pin_m1[PSEL_W-1:0];
   assign rise_ev = s_new[sel] & ~s_old[sel];
   assign fall_ev = ~s_new[sel] & s_old[sel];
   assign hit     = (dcnt == div);
   assign take    = ext ? ((rise & rise_ev) | (fall & fall_ev)) : hit;

   always_ff @(posedge clk) begin
      if (!rst_n)              dcnt <= 8'd0;
      else if (commit || hit)  dcnt <= 8'd0;
      else                     dcnt <= dcnt + 8'd1;
   end
endmodule

// File: rtl/xcap_stamp.sv
module xcap_stamp #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   output logic [TS_W-1:0] ts,
   output logic            mark_next
);
   logic seen;
   logic at_top;

   assign at_top    = (ts == {TS_W{1'b1}});
   assign mark_next = at_top && !seen && !take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts   <= '0;
         seen <= 1'b0;
      end else begin
         ts <= ts + TS_W'(1);
         if (at_top)    seen <= 1'b0;
         else if (take) seen <= 1'b1;
      end
   end
endmodule

// File: rtl/xcap_front.sv
module xcap_front
   import xcap_pkg::*;
#(
   parameter int NCH  = 16,
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_valid,
   input  logic [7:0]      cfg_byte,
   input  logic [NCH-1:0]  pins,
   output logic            smp_valid,
   output logic [NCH-1:0]  smp_data,
   output logic [TS_W-1:0] smp_ts,
   output logic            smp_mark
);
   if (NCH < 2 || NCH > 16 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $fatal(1, "NCH must be a power of two between 2 and 16");
   end
   if (TS_W < 8 || TS_W > 32) begin : g_bad_tsw
      $fatal(1, "TS_W must lie between 8 and 32");
   end

   cfg_t            act_cfg;
   logic            commit;
   logic [NCH-1:0]  s_new, s_old;
   logic            take;
   logic [TS_W-1:0] ts_now;
   logic            mark_next;

   xcap_cfg_loader u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
      .act(act_cfg), .commit(commit)
   );

   xcap_pin_sync #(.NCH(NCH)) u_sync (
      .clk(clk), .rst_n(rst_n), .pins(pins), .s_new(s_new), .s_old(s_old)
   );

   xcap_sample_ctl #(.NCH(NCH)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ext(act_cfg.ext), .pin_f(act_cfg.pin_f),
      .rise(act_cfg.rise), .fall(act_cfg.fall), .div(act_cfg.div),
      .commit(commit), .s_new(s_new), .s_old(s_old), .take(take)
   );

   xcap_stamp #(.TS_W(TS_W)) u_stamp (
      .clk(clk), .rst_n(rst_n), .take(take), .ts(ts_now), .mark_next(mark_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_data  <= '0;
         smp_ts    <= '0;
         smp_mark  <= 1'b0;
      end else begin
         smp_valid <= take;
         smp_data  <= s_new & ~act_cfg.mask[NCH-1:0];
         smp_ts    <= ts_now;
         smp_mark  <= mark_next;
      end
   end
endmodule

// File: rtl/xcap_front_chk.sv
module xcap_front_chk #(
   parameter int NCH  = 16,
   parameter int TS_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            smp_valid,
   input logic [NCH-1:0]  smp_data,
   input logic [TS_W-1:0] smp_ts,
   input logic            smp_mark,
   input logic            ext,
   input logic            rise,
   input logic            fall,
   input logic [7:0]      div,
   input logic [15:0]     mask,
   input logic            commit
);
   // R7: disabled channels never carry a 1
   assert_mask_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> ((smp_data & $past(mask[NCH-1:0])) == '0));

   // R6: external mode with no edge enabled yields nothing
   assert_no_edge_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> !($past(ext) && !$past(rise) && !$past(fall)));

   // R2: a nonzero divider leaves a gap after each internal sample
   assert_div_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !ext && (div != 8'd0) && !commit) |=> !smp_valid);

   // R10: marker is exclusive with samples and sits at the top count
   assert_mark_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      smp_mark |-> (!smp_valid && (smp_ts == {TS_W{1'b1}})));

   // R8: back-to-back samples carry consecutive timestamps
   assert_ts_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && $past(smp_valid)) |-> (smp_ts == TS_W'($past(smp_ts) + 1'b1)));
endmodule

bind xcap_front xcap_front_chk #(.NCH(NCH), .TS_W(TS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
   .smp_ts(smp_ts), .smp_mark(smp_mark), .ext(act_cfg.ext), .rise(act_cfg.rise),
   .fall(act_cfg.fall), .div(act_cfg.div), .mask(act_cfg.mask), .commit(commit)
);

// File: tb/tb_xcap_front.sv
module tb_xcap_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [7:0]  cfg_byte = 8'd0;
   logic [15:0] pins = 16'd0;
   logic        smp_valid, smp_mark;
   logic [15:0] smp_data, smp_ts;

   xcap_front dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_byte(cfg_byte),
      .pins(pins), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_ts(smp_ts), .smp_mark(smp_mark)
   );

   always #2 clk = ~clk;

   int    n_vec = 0;
   int    n_bad = 0;
   int    obs_marks = 0;
   bit    done = 0;
   string cur_req = "R1";

   // reference model state
   bit          m_ext = 0, m_rise = 0, m_fall = 0, m_seen = 0;
   int          m_field = 0, m_div = 0, m_phase = 0, m_tick = 0, m_slot = 0;
   logic [15:0] m_mask = 0;
   logic [7:0]  sh_mode = 0, sh_div = 0, sh_mhi = 0;
   logic [15:0] hist [$];
   bit          e_valid, e_mark;
   logic [15:0] e_data, e_ts;

   function automatic logic [7:0] ext_div(bit r, bit f, int ch);
      return {2'b00, f, r, 4'(ch + 1)};
   endfunction

   task automatic fail(string what, logic [31:0] act, logic [31:0] exp);
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h (t=%0t)", cur_req, what, act, exp, $time);
   endtask

   task automatic step(input logic [15:0] p, input bit cv, input logic [7:0] cb);
      int  pin;
      bit  a, b, take;
      pins = p; cfg_valid = cv; cfg_byte = cb;
      pin  = (m_field + 15) % 16;
      a    = hist[2][pin];
      b    = hist[1][pin];
      if (m_ext) take = (m_rise && !a && b) || (m_fall && a && !b);
      else       take = (m_phase == m_div);
      e_valid = take;
      e_data  = hist[1] & ~m_mask;
      e_ts    = 16'(m_tick);
      e_mark  = (m_tick == 65535) && !m_seen && !take;
      if (m_tick == 65535) m_seen = 0; else if (take) m_seen = 1;
      m_tick = (m_tick + 1) % 65536;
      if (cv && m_slot == 3) m_phase = 0;
      else if (m_phase == m_div) m_phase = 0;
      else m_phase++;
      if (cv) begin
         case (m_slot)
            0: sh_mode = cb;
            1: sh_div = cb;
            2: sh_mhi = cb;
            default: begin
               m_ext = sh_mode[0]; m_field = sh_div[3:0];
               m_rise = sh_div[4]; m_fall = sh_div[5];
               m_div = sh_div; m_mask = {sh_mhi, cb};
            end
         endcase
         m_slot = (m_slot + 1) % 4;
      end
      hist.push_front(p);
      void'(hist.pop_back());
      @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (smp_mark) obs_marks++;
      if (smp_valid !== e_valid) fail("valid", smp_valid, e_valid);
      if (smp_mark !== e_mark) fail("R9/R10 mark", smp_mark, e_mark);
      if (e_valid && smp_data !== e_data) fail("R7 data", smp_data, e_data);
      if (e_valid && smp_ts !== e_ts) fail("R8 ts", smp_ts, e_ts);
      if (e_mark && smp_ts !== 16'hFFFF) fail("R10 mark ts", smp_ts, 16'hFFFF);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step(16'($urandom), 1'b0, 8'd0);
   endtask

   task automatic send_cfg(logic [7:0] md, logic [7:0] dv, logic [15:0] mk);
      step(16'($urandom), 1'b1, md);
      step(16'($urandom), 1'b1, dv);
      step(16'($urandom), 1'b1, mk[15:8]);
      step(16'($urandom), 1'b1, mk[7:0]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      hist = '{16'h0, 16'h0, 16'h0};
      // R1: outputs idle during reset
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         n_vec++;
         if (smp_valid !== 1'b0) fail("R1 valid in reset", smp_valid, 0);
         if (smp_mark !== 1'b0) fail("R1 mark in reset", smp_mark, 0);
      end
      rst_n = 1'b1;
      // R1 then R2: reset config samples every cycle
      cur_req = "R1"; run(3);
      cur_req = "R2"; run(200);
      send_cfg(8'h00, 8'd2, 16'h0000);   run(300);
      send_cfg(8'h00, 8'd4, 16'h0000);   run(300);
      send_cfg(8'h00, 8'd9, 16'h0000);   run(300);
      // R3: half a configuration must not take effect
      cur_req = "R3";
      step(16'($urandom), 1'b1, 8'h01);
      step(16'($urandom), 1'b1, ext_div(1, 0, 3));
      run(40);
      step(16'($urandom), 1'b1, 8'h00);
      step(16'($urandom), 1'b1, 8'h00);
      run(300);
      // R7: disable mask
      cur_req = "R7";
      send_cfg(8'h00, 8'd0, 16'hF0F0);   run(200);
      send_cfg(8'h00, 8'd1, 16'h0FF1);   run(200);
      // R4/R6 external edge modes on channel 3
      cur_req = "R4 rise";
      send_cfg(8'h01, ext_div(1, 0, 3), 16'h0000);  run(300);
      cur_req = "R6 fall";
      send_cfg(8'h01, ext_div(0, 1, 3), 16'h0100);  run(300);
      cur_req = "R6 either";
      send_cfg(8'h01, ext_div(1, 1, 3), 16'h0000);  run(300);
      // R5: field value 0 selects channel 15
      cur_req = "R5";
      send_cfg(8'h01, 8'h30, 16'h0000);  run(300);
      send_cfg(8'h01, ext_div(1, 0, 0), 16'h8000); run(300);
      // R6 none, then R9 across two timestamp windows
      cur_req = "R6 none / R9";
      send_cfg(8'h01, 8'h07, 16'h0000);
      run(131100);
      n_vec++;
      if (obs_marks != 1) fail("R9 marker count", obs_marks, 1);
      finish_run();
   end
endmodule